// File: doc/BRIEF.md
# Frame-Buffer Pixel Unpacker with Colour Palette

The block turns a stream of 32-bit frame-buffer words into a stream of 24-bit RGB pixels, one pixel per output handshake. A word is taken on a valid/ready input and held in a single buffer. Its pixels are then presented one after another on a valid/ready output. The pixel depth is 1, 2, 4, 8, 16 or 24 bits. Depths of 8 bits and below can be mapped through a 256-entry colour table that software writes through a separate index/data port. 16-bit pixels are widened to 8 bits per channel, using one of two component layouts.

Three ordering modes choose how bytes are arranged in the word and how sub-byte pixels are arranged in a byte. The configuration inputs are expected to stay steady while pixels are flowing. A sticky underflow flag records every cycle in which the pixel consumer was ready but no word was buffered.

Top module: `pxu_unpacker`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and underflow is 0.
- R2: cfg_depth code c in 0..4 gives 2^c bits per pixel and 32>>c pixels per word; code 5 gives 24 bits and one pixel per word. A word is taken on a cycle with in_valid and in_ready both high. in_ready is high when no word is buffered, or when the last pixel of the buffered word is being consumed. Pixels are delivered in order and each is consumed on a cycle with out_valid and out_ready both high.
- R3: At depth codes 0..3 with cfg_pal_en=1, the pixel value indexes the colour table, and out_rgb is that entry. An entry holds red in bits 7:0, green in bits 15:8 and blue in bits 23:16; out_rgb uses the same positions.
- R4: At depth codes 0..3 with cfg_pal_en=0, the pixel value v of b bits becomes a grey level. The level is v*255/(2^b-1), and it is driven on all three channels.
- R5: At 16 bpp with cfg_layout=1, red is bits 15:11, green is bits 10:5 and blue is bits 4:0. Each channel widens to 8 bits by copying its top bits below it.
- R6: At 16 bpp with cfg_layout=0, blue is bits 15:11, green is bits 10:6 and red is bits 5:0. The channels widen the same way as in R5.
- R7: At 24 bpp the pixel is the low 24 bits of the (ordered) word, with red 7:0, green 15:8 and blue 23:16. The colour table is bypassed at 16 and 24 bpp.
- R8: cfg_order=0: pixel k occupies bits [k*bpp +: bpp] of the word.
- R9: cfg_order=1: the four bytes of the word are reversed first. Sub-byte pixels are then taken most-significant first within each byte. Pixels of 8 bits or more are taken from the low end of the reversed word.
- R10: cfg_order=2: the bytes stay in place, and sub-byte pixels are taken most-significant first within each byte. Depths of 8 bits and above behave as with code 0.
- R11: cfg_order=3 behaves exactly like code 0.
- R12: underflow becomes 1 on the cycle after out_ready=1 while out_valid=0. It stays 1 until a cycle with uf_clr=1, after which it reads 0, unless a new underflow occurs in that same cycle (setting wins).
- R13: A table write (pal_we=1) changes the entry from the next clock. During the write cycle itself, out_rgb still shows the old entry.
- R14: While out_valid=1 and out_ready=0 with no table write and steady configuration, out_rgb and out_valid do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_order | input | 2 | Byte and pixel ordering mode |
| cfg_layout | input | 1 | 16 bpp component layout |
| cfg_pal_en | input | 1 | Colour table enable for depths up to 8 bpp |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Frame-buffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel consumer ready |
| out_rgb | output | 24 | Pixel colour, red 7:0, green 15:8, blue 23:16 |
| pal_we | input | 1 | Colour table write enable |
| pal_addr | input | 8 | Colour table write index |
| pal_wdata | input | 24 | Colour table write data |
| uf_clr | input | 1 | Clear for the underflow flag |
| underflow | output | 1 | Sticky underflow flag |

## Verification
A word accepted at one clock edge shows its first pixel in the same cycle's afterglow: out_valid and out_rgb are valid right after that edge, because the colour path is combinational from the buffer. Each later pixel follows one edge after the consumer takes the previous one. The scoreboard therefore compares at the falling edge, on cycles where out_valid and out_ready are both high, before the rising edge that consumes the pixel. The underflow flag and table writes are due one edge after their cause. The directed checks look just before that edge, to confirm the old value, and at the next falling edge, to confirm the new one.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  localparam int unsigned CH_W  = 8;
  localparam int unsigned RGB_W = 3 * CH_W;

  typedef enum logic [2:0] {
    DEP_1  = 3'd0,
    DEP_2  = 3'd1,
    DEP_4  = 3'd2,
    DEP_8  = 3'd3,
    DEP_16 = 3'd4,
    DEP_24 = 3'd5
  } depth_e;

  typedef enum logic [1:0] {
    ORD_LL  = 2'd0,
    ORD_BB  = 2'd1,
    ORD_LB  = 2'd2,
    ORD_RSV = 2'd3
  } order_e;

  typedef struct packed {
    logic [CH_W-1:0] b;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] r;
  } rgb_t;

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

endpackage

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // storage array, no reset: written by software before use
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/pxu_slicer.sv
module pxu_slicer
  import pxu_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic [2:0]        depth,
  input  logic [1:0]        order,
  output logic [RGB_W-1:0]  raw,
  output logic              last
);
  logic [WORD_W-1:0] ordered;
  logic              sub_byte;
  logic              msb_first;
  logic [IDX_W-1:0]  flip;
  logic [IDX_W-1:0]  pos;
  logic [IDX_W-1:0]  shamt;
  logic [RGB_W-1:0]  mask;
  logic              wide24;

  always_comb begin
    wide24    = (depth > 3'd4);
    ordered   = (order_e'(order) == ORD_BB) ?
                {word[7:0], word[15:8], word[23:16], word[31:24]} : word;
    sub_byte  = (depth < 3'd3);
    msb_first = sub_byte && (order_e'(order) == ORD_BB || order_e'(order) == ORD_LB);
    flip      = sub_byte ? IDX_W'((5'd8 >> depth) - 5'd1) : '0;
    pos       = msb_first ? (idx ^ flip) : idx;
    shamt     = wide24 ? '0 : IDX_W'(pos << depth);
    mask      = wide24 ? {RGB_W{1'b1}} : ((RGB_W'(1) << (5'd1 << depth)) - RGB_W'(1));
    raw       = RGB_W'(ordered >> shamt) & mask;
    last      = wide24 ? 1'b1 : (idx == IDX_W'((6'd32 >> depth) - 6'd1));
  end

endmodule

// File: rtl/pxu_colour.sv
module pxu_colour
  import pxu_pkg::*;
#(
  parameter int unsigned PAL_AW = 8
) (
  input  logic [RGB_W-1:0]  raw,
  input  logic [2:0]        depth,
  input  logic              layout,
  input  logic              pal_en,
  input  logic [RGB_W-1:0]  pal_rdata,
  output logic [PAL_AW-1:0] pal_idx,
  output logic [RGB_W-1:0]  rgb
);
  rgb_t            pix;
  logic [CH_W-1:0] grey;

  assign pal_idx = raw[PAL_AW-1:0];

  always_comb begin
    unique case (depth)
      3'd0:    grey = {8{raw[0]}};
      3'd1:    grey = {4{raw[1:0]}};
      3'd2:    grey = {2{raw[3:0]}};
      default: grey = raw[7:0];
    endcase

    pix = rgb_t'(raw);
    if (depth < 3'd4) begin
      pix = pal_en ? rgb_t'(pal_rdata) : rgb_t'({grey, grey, grey});
    end else if (depth == 3'd4) begin
      if (layout) begin
        pix.r = widen5(raw[15:11]);
        pix.g = widen6(raw[10:5]);
        pix.b = widen5(raw[4:0]);
      end else begin
        pix.b = widen5(raw[15:11]);
        pix.g = widen5(raw[10:6]);
        pix.r = widen6(raw[5:0]);
      end
    end
    rgb = pix;
  end

endmodule

// File: rtl/pxu_unpacker.sv
module pxu_unpacker
  import pxu_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PAL_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_depth,
  input  logic [1:0]        cfg_order,
  input  logic              cfg_layout,
  input  logic              cfg_pal_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RGB_W-1:0]  out_rgb,
  input  logic              pal_we,
  input  logic [PAL_AW-1:0] pal_addr,
  input  logic [RGB_W-1:0]  pal_wdata,
  input  logic              uf_clr,
  output logic              underflow
);
  localparam int unsigned IDX_W = $clog2(WORD_W);

  logic              full_q, full_d;
  logic [WORD_W-1:0] word_q;
  logic              word_en;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              uflow_q, uflow_d;

  logic              in_fire, out_fire, last;
  logic [RGB_W-1:0]  raw;
  logic [PAL_AW-1:0] pal_idx;
  logic [RGB_W-1:0]  pal_rdata;

  pxu_slicer #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_slicer (
    .word  (word_q),
    .idx   (idx_q),
    .depth (cfg_depth),
    .order (cfg_order),
    .raw   (raw),
    .last  (last)
  );

  pxu_palette #(.AW(PAL_AW), .DW(RGB_W)) u_palette (
    .clk   (clk),
    .we    (pal_we),
    .waddr (pal_addr),
    .wdata (pal_wdata),
    .raddr (pal_idx),
    .rdata (pal_rdata)
  );

  pxu_colour #(.PAL_AW(PAL_AW)) u_colour (
    .raw       (raw),
    .depth     (cfg_depth),
    .layout    (cfg_layout),
    .pal_en    (cfg_pal_en),
    .pal_rdata (pal_rdata),
    .pal_idx   (pal_idx),
    .rgb       (out_rgb)
  );

  // next-state logic
  always_comb begin
    out_fire = full_q & out_ready;
    in_ready = ~full_q | (out_ready & last);
    in_fire  = in_valid & in_ready;
    word_en  = in_fire;

    full_d = full_q;
    idx_d  = idx_q;
    if (in_fire) begin
      full_d = 1'b1;
      idx_d  = '0;
    end else if (out_fire) begin
      full_d = ~last;
      idx_d  = idx_q + IDX_W'(1);
    end

    uflow_d = (uflow_q & ~uf_clr) | (out_ready & ~full_q);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      idx_q   <= '0;
      uflow_q <= 1'b0;
    end else begin
      full_q  <= full_d;
      idx_q   <= idx_d;
      uflow_q <= uflow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= in_data;
    end
  end

  assign out_valid = full_q;
  assign underflow = uflow_q;

endmodule

// File: rtl/pxu_unpacker_chk.sv
module pxu_unpacker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cfg_depth,
  input logic [1:0]  cfg_order,
  input logic        cfg_layout,
  input logic        cfg_pal_en,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_rgb,
  input logic        pal_we,
  input logic        uf_clr,
  input logic        underflow
);

  // R2: a stalled word blocks the input
  a_r2_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: at 24 bpp every consumed pixel frees the buffer
  a_r7_one_per_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && cfg_depth == 3'd5) |-> in_ready);

  // R14: stalled pixel holds
  a_r14_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !pal_we) |=>
      (out_valid && ($stable(out_rgb) || !$stable(cfg_depth) || !$stable(cfg_order)
                     || !$stable(cfg_layout) || !$stable(cfg_pal_en))));

  // R12: set, hold and clear of the underflow flag
  a_r12_uflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid) |=> underflow);

  a_r12_uflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !uf_clr) |=> underflow);

  a_r12_uflow_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_clr && !(out_ready && !out_valid)) |=> !underflow);

endmodule

bind pxu_unpacker pxu_unpacker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_depth  (cfg_depth),
  .cfg_order  (cfg_order),
  .cfg_layout (cfg_layout),
  .cfg_pal_en (cfg_pal_en),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_rgb    (out_rgb),
  .pal_we     (pal_we),
  .uf_clr     (uf_clr),
  .underflow  (underflow)
);

// File: tb/pxu_unpacker_tb.sv
`timescale 1ns/1ps
module pxu_unpacker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_depth = 3'd0;
  logic [1:0]  cfg_order = 2'd0;
  logic        cfg_layout = 1'b0;
  logic        cfg_pal_en = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] out_rgb;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = '0;
  logic [23:0] pal_wdata = '0;
  logic        uf_clr = 1'b0;
  logic        underflow;

  int checks = 0;
  int errors = 0;
  logic [23:0] tb_pal [256];
  logic [23:0] expq [$];
  string       cur_req = "R2";
  int          bp_mode = 0;   // 0 low, 1 high, 2 random
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;   // 50 MHz

  pxu_unpacker u_dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_depth (cfg_depth), .cfg_order (cfg_order),
    .cfg_layout (cfg_layout), .cfg_pal_en (cfg_pal_en),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .out_valid (out_valid), .out_ready (out_ready), .out_rgb (out_rgb),
    .pal_we (pal_we), .pal_addr (pal_addr), .pal_wdata (pal_wdata),
    .uf_clr (uf_clr), .underflow (underflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] w5(input logic [4:0] c);
    return 8'((c << 3) | (c >> 2));
  endfunction
  function automatic logic [7:0] w6(input logic [5:0] c);
    return 8'((c << 2) | (c >> 4));
  endfunction

  function automatic logic [23:0] model(input logic [31:0] w, input int k);
    logic [31:0] ww, v;
    int bpp, ppb, pos;
    logic [7:0] r, g, b, gr;
    ww = (cfg_order == 2'd1) ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    if (cfg_depth == 3'd5) return ww[23:0];
    bpp = 1 << cfg_depth;
    pos = k;
    if (bpp < 8 && (cfg_order == 2'd1 || cfg_order == 2'd2)) begin
      ppb = 8 / bpp;
      pos = (k / ppb) * ppb + (ppb - 1 - (k % ppb));
    end
    v = (ww >> (pos * bpp)) & ((32'd1 << bpp) - 32'd1);
    if (cfg_depth <= 3'd3) begin
      if (cfg_pal_en) return tb_pal[v[7:0]];
      gr = 8'((v * 255) / ((32'd1 << bpp) - 32'd1));
      return {gr, gr, gr};
    end
    if (cfg_layout) begin
      r = w5(v[15:11]); g = w6(v[10:5]); b = w5(v[4:0]);
    end else begin
      b = w5(v[15:11]); g = w5(v[10:6]); r = w6(v[5:0]);
    end
    return {b, g, r};
  endfunction

  function automatic int px_per_word();
    return (cfg_depth == 3'd5) ? 1 : (32 >> cfg_depth);
  endfunction

  // backpressure driver: changes just after the rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (bp_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = lfsr[0] | lfsr[3];
    endcase
  end

  // monitor: compares each consumed pixel against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s actual %h expected none (unexpected pixel)", cur_req, out_rgb);
      end else begin
        check(cur_req, {8'd0, out_rgb}, {8'd0, expq.pop_front()});
      end
    end
  end

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    for (int k = 0; k < px_per_word(); k++) expq.push_back(model(w, k));
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] next_word();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic run_phase(input int d, input int o, input bit pe, input bit lay);
    string tag;
    @(negedge clk);
    cfg_depth = 3'(d); cfg_order = 2'(o); cfg_pal_en = pe; cfg_layout = lay;
    if (d <= 3) tag = pe ? "R3" : "R4";
    else if (d == 4) tag = lay ? "R5" : "R6";
    else tag = "R7";
    case (o)
      0: cur_req = $sformatf("R2/%s/R8", tag);
      1: cur_req = $sformatf("R2/%s/R9", tag);
      2: cur_req = $sformatf("R2/%s/R10", tag);
      default: cur_req = $sformatf("R2/%s/R11", tag);
    endcase
    send_word(32'h0123_4567);
    send_word(32'hF0E1_D2C3);
    for (int i = 0; i < 4; i++) send_word(next_word());
    drain();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 underflow", {31'd0, underflow}, 32'd0);

    // fill colour table
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      tb_pal[i] = 24'((i * 7 + 3) | ((i ^ 8'hA5) << 8) | (((i * 13) & 8'hFF) << 16));
      pal_we = 1'b1; pal_addr = 8'(i); pal_wdata = tb_pal[i];
    end
    @(negedge clk);
    pal_we = 1'b0;

    // R12 underflow set, sticky, clear
    bp_mode = 1;
    @(posedge clk); @(negedge clk);
    bp_mode = 0;
    @(posedge clk); @(negedge clk);
    check("R12 set", {31'd0, underflow}, 32'd1);
    @(posedge clk); @(negedge clk);
    check("R12 sticky", {31'd0, underflow}, 32'd1);
    uf_clr = 1'b1;
    @(negedge clk);
    uf_clr = 1'b0;
    check("R12 clear", {31'd0, underflow}, 32'd0);

    // R13 table write timing and R14 stall hold, 8 bpp, index 0x5A
    cfg_depth = 3'd3; cfg_order = 2'd0; cfg_pal_en = 1'b1;
    in_valid = 1'b1; in_data = 32'h1122_335A;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check("R13 before write", {8'd0, out_rgb}, {8'd0, tb_pal[8'h5A]});
    check("R2 stalled in_ready", {31'd0, in_ready}, 32'd0);
    pal_we = 1'b1; pal_addr = 8'h5A; pal_wdata = 24'hC0FFEE;
    #1 check("R13 same cycle old", {8'd0, out_rgb}, {8'd0, tb_pal[8'h5A]});
    @(negedge clk);
    pal_we = 1'b0;
    tb_pal[8'h5A] = 24'hC0FFEE;
    check("R13 after write", {8'd0, out_rgb}, {8'd0, 24'hC0FFEE});
    @(negedge clk);
    check("R14 stall hold", {8'd0, out_rgb}, {8'd0, 24'hC0FFEE});
    for (int k = 0; k < 4; k++) expq.push_back(model(32'h1122_335A, k));
    cur_req = "R13/R8";
    bp_mode = 1;
    drain();

    // main sweep with random backpressure
    bp_mode = 2;
    for (int d = 0; d < 6; d++)
      for (int o = 0; o < 4; o++) begin
        if (d <= 3) begin
          run_phase(d, o, 1'b1, 1'b0);
          run_phase(d, o, 1'b0, 1'b0);
        end else if (d == 4) begin
          run_phase(d, o, 1'b0, 1'b1);
          run_phase(d, o, 1'b0, 1'b0);
        end else begin
          run_phase(d, o, 1'b1, 1'b0);
        end
      end

    // back-to-back words with consumer always ready
    bp_mode = 1;
    run_phase(2, 2, 1'b1, 1'b0);
    run_phase(5, 1, 1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule